// File: doc/BRIEF.md
# Flash Identification Probe Sequencer

This block identifies a byte-wide, command-driven flash device that sits on a simple synchronous memory bus. The bus carries an address, write data, read data, a write strobe, a read strobe and a ready handshake. A probe runs once after reset when automatic start is enabled. It also runs on any start pulse that arrives while the block is idle. During a probe the sequencer puts the device into identify mode, waits a programmable settle time, and reads two identification bytes. It then puts the device back into array-read mode.

The location of the second identification byte depends on the first byte. Most devices place it directly after the first byte. A device whose manufacturer byte reads 0xB0 places it two bytes above the base instead. The two bytes are joined into a 16-bit ID. The ID is compared against the two supported devices, and the result is a supported flag and a capacity select: small is 1 MiB, large is 4 MiB. The result appears with a one-cycle done pulse and stays on the outputs until the next probe ends.

Top module: `flash_id_probe`

## Requirements
- R1: While reset is asserted, both bus strobes, done_o, id_valid_o, cap_large_o and busy_o are 0, and id_o is 0.
- R2: A probe starts after reset when AUTO_START is 1, or on start_i while idle. Its first bus access writes byte 0x90 to offset 0x8000.
- R3: The manufacturer read strobe rises no earlier than SETTLE_CYC clock cycles after the clock edge that completes the identify write.
- R4: The manufacturer byte is read from offset 0. The device byte is then read from offset 2 if the manufacturer byte is 0xB0, and from offset 1 otherwise.
- R5: id_o carries the manufacturer byte in bits 15:8 and the device byte in bits 7:0.
- R6: The last bus access of a probe writes 0xFF to offset 0x8000, and it comes before done_o.
- R7: ID 0x89A6 gives id_valid_o=1 and cap_large_o=0. ID 0xB0D4 gives id_valid_o=1 and cap_large_o=1. Any other ID gives id_valid_o=0 and cap_large_o=0.
- R8: done_o is high for exactly one cycle per probe. id_o, id_valid_o and cap_large_o take their new values in that cycle and hold them until the next probe's done.
- R9: Only one strobe is active at a time. While a strobe is active and ready is low, the strobe, the address and the write data stay unchanged.
- R10: busy_o is high from the start of a probe until done_o. A probe makes exactly four bus accesses and one done pulse. A start pulse that arrives while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Probe request pulse, only taken while idle |
| bus_addr_o | output | ADDR_W | Byte offset of the current access |
| bus_wdata_o | output | 8 | Write data byte |
| bus_rdata_i | input | 8 | Read data byte, sampled when ready is high |
| bus_wr_o | output | 1 | Write strobe, held until ready |
| bus_rd_o | output | 1 | Read strobe, held until ready |
| bus_rdy_i | input | 1 | Access completes on a clock edge where ready is high |
| busy_o | output | 1 | A probe is in progress |
| done_o | output | 1 | One-cycle pulse when a probe finishes |
| id_valid_o | output | 1 | Last ID matched a supported device |
| cap_large_o | output | 1 | Last ID selects the 4 MiB capacity |
| id_o | output | 16 | Last assembled 16-bit ID |

## Verification
The assertions check the bus rules on every cycle: only one strobe at a time, and the strobe, address and data held steady through wait states. They also check that strobes stay quiet while idle, that done is a single-cycle pulse, that the result holds between probes, and that the settle window is respected. They further check that a supported flag always comes with one of the two known IDs.

Other behaviour can only be shown by the bench's scenarios, which run against a responder that has an identify mode and wait states. These include the choice of device-byte offset from the manufacturer byte, the exact order of the four accesses, the restoration of array-read mode, and the decoding of supported and unsupported IDs. They also include that a start pulse during a probe is ignored.

// File: rtl/flid_pkg.sv
// Shared constants and types for the flash identification probe.
// Assumes byte offsets on the bus are at least 16 bits wide.
package flid_pkg;

    // Command bytes understood by the attached flash device
    localparam logic [7:0] CMD_IDENTIFY = 8'h90;
    localparam logic [7:0] CMD_ARRAY    = 8'hFF;

    // Offsets used by the probe
    localparam int unsigned OFS_COMMAND = 32'h0000_8000;
    localparam int unsigned OFS_MFR     = 32'h0000_0000;
    localparam int unsigned OFS_DEV_STD = 32'h0000_0001;
    localparam int unsigned OFS_DEV_ALT = 32'h0000_0002;

    // Manufacturer byte that moves the device byte to the alternate offset
    localparam logic [7:0] MFR_ALT_LAYOUT = 8'hB0;

    // Supported identities
    localparam logic [15:0] ID_SMALL = 16'h89A6;
    localparam logic [15:0] ID_LARGE = 16'hB0D4;

    typedef enum logic [2:0] {
        PS_IDLE    = 3'd0,
        PS_ID_CMD  = 3'd1,
        PS_SETTLE  = 3'd2,
        PS_RD_MFR  = 3'd3,
        PS_RD_DEV  = 3'd4,
        PS_RESTORE = 3'd5
    } probe_state_t;

endpackage

// File: rtl/flid_bus_port.sv
// Single-outstanding bus access engine.
// Accepts a one-cycle request while idle, drives the strobe, address and
// data from registers until ready is seen on a clock edge, then returns a
// one-cycle ack on the following cycle with the read byte captured.
// Assumes the requester does not issue a new request before the ack.
module flid_bus_port #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [7:0]        req_wdata_i,
    output logic              ack_o,
    output logic [7:0]        rdata_o,
    output logic              bus_wr_o,
    output logic              bus_rd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    input  logic [7:0]        bus_rdata_i,
    input  logic              bus_rdy_i
);

    logic wr_q, rd_q, ack_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0] wdata_q, rdata_q;
    logic active;

    assign active = wr_q | rd_q;

    // Launch an access, hold it through wait states, retire it on ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            ack_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            ack_q <= 1'b0;
            if (!active && req_i) begin
                wr_q    <= req_wr_i;
                rd_q    <= !req_wr_i;
                addr_q  <= req_addr_i;
                wdata_q <= req_wr_i ? req_wdata_i : 8'h00;
            end else if (active && bus_rdy_i) begin
                wr_q  <= 1'b0;
                rd_q  <= 1'b0;
                ack_q <= 1'b1;
                if (rd_q) begin
                    rdata_q <= bus_rdata_i;
                end
            end
        end
    end

    assign ack_o       = ack_q;
    assign rdata_o     = rdata_q;
    assign bus_wr_o    = wr_q;
    assign bus_rd_o    = rd_q;
    assign bus_addr_o  = addr_q;
    assign bus_wdata_o = wdata_q;

endmodule

// File: rtl/flid_settle_timer.sv
// Settle delay counter.
// Counts clock cycles while run_i is held and flags the last one, so the
// settle phase lasts exactly SETTLE_CYC cycles. Clears whenever run_i drops.
// Assumes SETTLE_CYC is at least 1.
module flid_settle_timer #(
    parameter int SETTLE_CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance while running, restart from zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || expired_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/flid_id_decode.sv
// Identity decoder.
// From the manufacturer byte it chooses where the device byte lives. From
// both bytes it forms the 16-bit ID and classifies it against the supported
// devices. Purely combinational.
module flid_id_decode
    import flid_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [7:0]        mfr_i,
    input  logic [7:0]        dev_i,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic [15:0]       id_o,
    output logic              supported_o,
    output logic              large_o
);

    // Device byte location depends on the manufacturer layout
    always_comb begin
        if (mfr_i == MFR_ALT_LAYOUT) begin
            dev_addr_o = ADDR_W'(OFS_DEV_ALT);
        end else begin
            dev_addr_o = ADDR_W'(OFS_DEV_STD);
        end
    end

    assign id_o = {mfr_i, dev_i};

    // Match against the two known identities
    always_comb begin
        supported_o = 1'b0;
        large_o     = 1'b0;
        if (id_o == ID_SMALL) begin
            supported_o = 1'b1;
        end else if (id_o == ID_LARGE) begin
            supported_o = 1'b1;
            large_o     = 1'b1;
        end
    end

endmodule

// File: rtl/flash_id_probe.sv
// Flash identification probe sequencer (top).
// Sequence: identify command, settle wait, manufacturer read, device read at
// a layout-dependent offset, array-read restore, then a done pulse with the
// classified ID. Runs once after reset if AUTO_START is set, and on start_i
// while idle. Assumes the bus completes every access eventually.
module flash_id_probe
    import flid_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int SETTLE_CYC = 3000,
    parameter bit AUTO_START = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    input  logic [7:0]        bus_rdata_i,
    output logic              bus_wr_o,
    output logic              bus_rd_o,
    input  logic              bus_rdy_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              id_valid_o,
    output logic              cap_large_o,
    output logic [15:0]       id_o
);

    localparam logic [ADDR_W-1:0] ADDR_CMD = ADDR_W'(OFS_COMMAND);
    localparam logic [ADDR_W-1:0] ADDR_MFR = ADDR_W'(OFS_MFR);

    probe_state_t state_q;
    logic issued_q, auto_q;
    logic [7:0] mfr_q, dev_q;
    logic done_q, valid_q, large_q;
    logic [15:0] id_q;

    logic access, req, req_wr, ack, expired;
    logic [ADDR_W-1:0] req_addr, dev_addr;
    logic [7:0] req_wdata, rdata;
    logic [15:0] dec_id;
    logic dec_supported, dec_large;

    // Decide which access, if any, the current step needs
    always_comb begin
        access    = 1'b0;
        req_wr    = 1'b0;
        req_addr  = ADDR_CMD;
        req_wdata = 8'h00;
        unique case (state_q)
            PS_ID_CMD: begin
                access    = 1'b1;
                req_wr    = 1'b1;
                req_wdata = CMD_IDENTIFY;
            end
            PS_RD_MFR: begin
                access   = 1'b1;
                req_addr = ADDR_MFR;
            end
            PS_RD_DEV: begin
                access   = 1'b1;
                req_addr = dev_addr;
            end
            PS_RESTORE: begin
                access    = 1'b1;
                req_wr    = 1'b1;
                req_wdata = CMD_ARRAY;
            end
            default: access = 1'b0;
        endcase
    end

    assign req = access && !issued_q;

    flid_bus_port #(.ADDR_W(ADDR_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .req_wr_i    (req_wr),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .ack_o       (ack),
        .rdata_o     (rdata),
        .bus_wr_o    (bus_wr_o),
        .bus_rd_o    (bus_rd_o),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_rdata_i (bus_rdata_i),
        .bus_rdy_i   (bus_rdy_i)
    );

    flid_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == PS_SETTLE),
        .expired_o (expired)
    );

    flid_id_decode #(.ADDR_W(ADDR_W)) u_decode (
        .mfr_i       (mfr_q),
        .dev_i       (dev_q),
        .dev_addr_o  (dev_addr),
        .id_o        (dec_id),
        .supported_o (dec_supported),
        .large_o     (dec_large)
    );

    // Remember that the current step's access has been handed to the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_q <= 1'b0;
        end else if (ack) begin
            issued_q <= 1'b0;
        end else if (req) begin
            issued_q <= 1'b1;
        end
    end

    // Step through the probe and publish the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            auto_q  <= AUTO_START;
            mfr_q   <= '0;
            dev_q   <= '0;
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            large_q <= 1'b0;
            id_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                PS_IDLE: begin
                    if (start_i || auto_q) begin
                        state_q <= PS_ID_CMD;
                        auto_q  <= 1'b0;
                    end
                end
                PS_ID_CMD: begin
                    if (ack) state_q <= PS_SETTLE;
                end
                PS_SETTLE: begin
                    if (expired) state_q <= PS_RD_MFR;
                end
                PS_RD_MFR: begin
                    if (ack) begin
                        mfr_q   <= rdata;
                        state_q <= PS_RD_DEV;
                    end
                end
                PS_RD_DEV: begin
                    if (ack) begin
                        dev_q   <= rdata;
                        state_q <= PS_RESTORE;
                    end
                end
                PS_RESTORE: begin
                    if (ack) begin
                        done_q  <= 1'b1;
                        id_q    <= dec_id;
                        valid_q <= dec_supported;
                        large_q <= dec_large;
                        state_q <= PS_IDLE;
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != PS_IDLE);
    assign done_o      = done_q;
    assign id_valid_o  = valid_q;
    assign cap_large_o = large_q;
    assign id_o        = id_q;

endmodule

// File: rtl/flid_checker.sv
// Protocol and result checker for flash_id_probe, attached by bind.
// Observes only the top-level ports; a small counter tracks the settle window.
module flid_checker #(
    parameter int ADDR_W     = 22,
    parameter int SETTLE_CYC = 3000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [7:0]        bus_wdata_o,
    input logic              bus_wr_o,
    input logic              bus_rd_o,
    input logic              bus_rdy_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              id_valid_o,
    input logic              cap_large_o,
    input logic [15:0]       id_o
);

    logic armed_q, rd_prev_q;
    logic [31:0] gap_q;

    // Measure cycles since the identify write completed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            rd_prev_q <= 1'b0;
            gap_q     <= '0;
        end else begin
            rd_prev_q <= bus_rd_o;
            if (bus_wr_o && bus_rdy_i && bus_wdata_o == 8'h90) begin
                armed_q <= 1'b1;
                gap_q   <= '0;
            end else begin
                if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 1;
                if (bus_rd_o && !rd_prev_q) armed_q <= 1'b0;
            end
        end
    end

    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_o && bus_rd_o));

    a_r9_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr_o || bus_rd_o) && !bus_rdy_i) |=>
            ($stable(bus_wr_o) && $stable(bus_rd_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bus_wr_o && !bus_rd_o));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(id_o) && $stable(id_valid_o) && $stable(cap_large_o)));

    a_r7_known_ids: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid_o |-> (id_o == 16'h89A6 || id_o == 16'hB0D4));

    a_r7_large_id: assert property (@(posedge clk) disable iff (!rst_n)
        cap_large_o |-> (id_valid_o && id_o == 16'hB0D4));

    a_r3_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && bus_rd_o && !rd_prev_q) |-> (gap_q >= 32'(SETTLE_CYC)));

endmodule

bind flash_id_probe flid_checker #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_flid_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_wr_o    (bus_wr_o),
    .bus_rd_o    (bus_rd_o),
    .bus_rdy_i   (bus_rdy_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .id_valid_o  (id_valid_o),
    .cap_large_o (cap_large_o),
    .id_o        (id_o)
);

// File: tb/test_flash_id_probe.sv
module test_flash_id_probe;

    localparam int AW  = 22;
    localparam int SET = 40;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] bus_addr_o;
    logic [7:0] bus_wdata_o;
    logic [7:0] bus_rdata_i = 8'h00;
    logic bus_wr_o, bus_rd_o;
    logic bus_rdy_i = 1'b0;
    logic busy_o, done_o, id_valid_o, cap_large_o;
    logic [15:0] id_o;

    flash_id_probe #(.ADDR_W(AW), .SETTLE_CYC(SET), .AUTO_START(1'b1)) i_flash_id_probe (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
        .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_rdy_i(bus_rdy_i),
        .busy_o(busy_o), .done_o(done_o), .id_valid_o(id_valid_o),
        .cap_large_o(cap_large_o), .id_o(id_o)
    );

    typedef struct packed { logic w; logic [AW-1:0] a; logic [7:0] d; } op_t;
    typedef struct packed { logic v; logic l; logic [15:0] id; } res_t;

    op_t   exp_ops[$];
    string exp_tag[$];
    res_t  exp_res[$];

    int n_cmp = 0, n_bad = 0, cyc = 0, n_done = 0;
    logic [7:0] m_mfr = 0, m_b1 = 0, m_b2 = 0;
    logic id_mode = 1'b0;
    int lat = 0, wcnt = 0, t_idw = 0;
    bit rd_seen = 1'b1;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Responder: flash model with identify mode and wait states, plus bus-op scoreboard
    always @(negedge clk) begin
        if (bus_rd_o && !rd_seen) begin
            rd_seen = 1'b1;
            chk((cyc - (t_idw + 1)) >= SET, "R3", "settle gap", cyc - (t_idw + 1), SET);
        end
        if (!(bus_wr_o || bus_rd_o)) begin
            bus_rdy_i = 1'b0;
            wcnt = 0;
        end else if (!bus_rdy_i) begin
            if (wcnt >= lat) begin
                op_t e;
                string t;
                bus_rdy_i = 1'b1;
                if (exp_ops.size() == 0) begin
                    chk(1'b0, "R10", "unexpected bus access", bus_addr_o, 0);
                end else begin
                    e = exp_ops.pop_front();
                    t = exp_tag.pop_front();
                    chk(bus_wr_o == e.w, t, "access kind", bus_wr_o, e.w);
                    chk(bus_addr_o == e.a, t, "access offset", bus_addr_o, e.a);
                    if (e.w) chk(bus_wdata_o == e.d, t, "write byte", bus_wdata_o, e.d);
                end
                if (bus_wr_o) begin
                    if (bus_wdata_o == 8'h90) begin
                        id_mode = 1'b1;
                        t_idw = cyc;
                        rd_seen = 1'b0;
                    end else if (bus_wdata_o == 8'hFF) begin
                        id_mode = 1'b0;
                    end
                end else if (id_mode) begin
                    case (bus_addr_o)
                        22'd0:   bus_rdata_i = m_mfr;
                        22'd1:   bus_rdata_i = m_b1;
                        22'd2:   bus_rdata_i = m_b2;
                        default: bus_rdata_i = 8'h00;
                    endcase
                end else begin
                    bus_rdata_i = bus_addr_o[7:0] ^ 8'h5A;
                end
            end else begin
                wcnt++;
            end
        end
    end

    // Monitor: compare each done result against the expected queue
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            res_t r;
            n_done++;
            if (exp_res.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", id_o, 0);
            end else begin
                r = exp_res.pop_front();
                chk(id_o == r.id, "R5", "assembled id", id_o, r.id);
                chk(id_valid_o == r.v, "R7", "supported flag", id_valid_o, r.v);
                chk(cap_large_o == r.l, "R7", "capacity select", cap_large_o, r.l);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk(1'b0, "R10", "watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    // Driver: push expected accesses and result, then trigger one probe
    task automatic run_probe(input logic [7:0] mfr, input logic [7:0] b1, input logic [7:0] b2,
                             input int wait_st, input bit auto_go, input bit poke);
        logic [7:0] dev;
        logic [15:0] id;
        res_t r;
        int d0, guard;
        m_mfr = mfr; m_b1 = b1; m_b2 = b2; lat = wait_st;
        dev = (mfr == 8'hB0) ? b2 : b1;
        id = {mfr, dev};
        exp_ops.push_back('{1'b1, 22'h8000, 8'h90}); exp_tag.push_back("R2");
        exp_ops.push_back('{1'b0, 22'h0, 8'h00});    exp_tag.push_back("R4");
        exp_ops.push_back('{1'b0, (mfr == 8'hB0) ? 22'h2 : 22'h1, 8'h00}); exp_tag.push_back("R4");
        exp_ops.push_back('{1'b1, 22'h8000, 8'hFF}); exp_tag.push_back("R6");
        r.id = id;
        r.v = (id == 16'h89A6) || (id == 16'hB0D4);
        r.l = (id == 16'hB0D4);
        exp_res.push_back(r);
        d0 = n_done;
        @(negedge clk);
        if (auto_go) begin
            rst_n = 1'b1;
        end else begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            #1 chk(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
        end
        if (poke) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (SET) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (n_done == d0 && guard < 3000) begin
            @(negedge clk);
            #1;
            guard++;
        end
        chk(n_done == d0 + 1, "R8", "done seen", n_done - d0, 1);
        @(negedge clk);
        #1;
        chk(done_o == 1'b0, "R8", "done single cycle", done_o, 0);
        chk(busy_o == 1'b0, "R10", "idle after done", busy_o, 0);
        repeat (20) @(negedge clk);
        #1;
        chk(exp_ops.size() == 0, "R10", "accesses left over", exp_ops.size(), 0);
        chk(n_done == d0 + 1, "R10", "one done per probe", n_done - d0, 1);
        chk(id_mode == 1'b0, "R6", "device back in array mode", id_mode, 0);
        chk(id_o == id, "R8", "id held", id_o, id);
        chk(id_valid_o == r.v, "R8", "flag held", id_valid_o, r.v);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_wr_o && !bus_rd_o, "R1", "strobes in reset", {bus_wr_o, bus_rd_o}, 0);
        chk(done_o == 0 && busy_o == 0, "R1", "done/busy in reset", {done_o, busy_o}, 0);
        chk(id_valid_o == 0 && cap_large_o == 0, "R1", "flags in reset", {id_valid_o, cap_large_o}, 0);
        chk(id_o == 16'h0, "R1", "id in reset", id_o, 0);

        run_probe(8'h89, 8'hA6, 8'h55, 0, 1'b1, 1'b0);   // R2 auto start, small device
        run_probe(8'hB0, 8'h11, 8'hD4, 2, 1'b0, 1'b0);   // R4 alternate offset, large device
        run_probe(8'h89, 8'hA6, 8'hD4, 3, 1'b0, 1'b1);   // R10 start while busy ignored
        run_probe(8'h89, 8'hA7, 8'h00, 1, 1'b0, 1'b0);   // R7 unsupported
        run_probe(8'hB0, 8'hD4, 8'hA6, 4, 1'b0, 1'b0);   // R4 picks offset 2 -> B0A6 unsupported
        run_probe(8'h12, 8'h34, 8'h56, 5, 1'b0, 1'b0);   // R7 unknown maker
        run_probe(8'hB0, 8'h00, 8'hD4, 0, 1'b0, 1'b0);   // R7 large again, zero wait

        finish_run();
    end

endmodule